// File: doc/BRIEF.md
# Clock Source Switch and CPU Clock Divider

This block chooses the oscillator that feeds a processor from six possible source kinds. Software selects a source by writing a 3-bit code. Each source is modelled as a single-cycle enable tick on one shared system clock. When a new code is accepted, the block holds its clock output off and clears a ready flag. It then waits a settling delay that depends on the kind of source. Crystal sources wait a count of their own ticks followed by a fixed number of system cycles. The low-power watchdog oscillator and the external clock pin wait a short count of their own ticks. The on-chip RC oscillator waits a fixed number of system cycles. When the delay ends, the ready flag sets and the selected ticks flow again.

The gated oscillator ticks then pass through an 8-bit divider. A divider value N greater than zero gives one processor-clock tick for every 2N oscillator ticks. N equal to zero lets every oscillator tick through. An optional clock output toggles once per processor-clock tick, so it runs at half the processor-clock rate. The divider value can be rewritten at any time. A new value is adopted only at the end of the period in progress. The code selected out of reset is taken from a configuration input.

Top module: `clksw_top`

## Requirements
- R1: While reset is asserted, `clk_ok`, `cpu_tick` and `ckout` are 0 and `cur_sel` equals `cfg_sel`. A reserved `cfg_sel` (101 or 110) is replaced by 011. After reset is released, the start-up delay for that source runs. For 011, the first cycle with `clk_ok` high comes RC_WAIT-1 cycles after the first sampled edge.
- R2: The code maps to the source tick as follows: 000 uses `src_tick[0]` (fast crystal), 001 uses `src_tick[1]` (mid crystal), 010 uses `src_tick[2]` (slow crystal), 011 uses `src_tick[3]` (RC), 100 uses `src_tick[4]` (watchdog oscillator) and 111 uses `src_tick[5]` (external pin). While `clk_ok` is 1, `osc_tick` follows the tick of the selected source and `cur_sel` shows the code.
- R3: After a crystal code (000, 001 or 010) is accepted, `clk_ok` stays 0 for XTAL_CNT ticks of the new source plus XTAL_SETTLE system cycles.
- R4: After code 100 or 111 is accepted, `clk_ok` stays 0 until FAST_CNT ticks of the new source have been seen.
- R5: After code 011 is accepted, `clk_ok` stays 0 for exactly RC_WAIT system cycles, whatever the source ticks do.
- R6: An accepted write clears `clk_ok` in the same edge. While `clk_ok` is 0, `osc_tick` is 0, and `cpu_tick` is 0 in every cycle that follows a cycle in which `clk_ok` was 0.
- R7: A control write made while `clk_ok` is 0 is ignored. It neither changes `cur_sel` nor restarts the delay in progress.
- R8: A control write with a reserved code (101 or 110) is ignored. `clk_ok` stays 1 and `cur_sel` is unchanged.
- R9: With divider value N=0, `cpu_tick` pulses once per `osc_tick`. With N from 1 to 255, `cpu_tick` pulses once per 2N oscillator ticks, so N=255 divides by 510.
- R10: A divider write takes effect at the next terminal count. The period in progress completes at the old length, and the next period uses the new length.
- R11: With `ckout_en` set, `ckout` toggles once per `cpu_tick`. With `ckout_en` clear, `ckout` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 3 | Source code loaded at reset |
| src_tick | input | 6 | Per-source enable ticks, indexed as in R2 |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 3 | Source code carried by a control write |
| div_we | input | 1 | Divider write strobe |
| div_val | input | 8 | Divider value N |
| ckout_en | input | 1 | Enables the half-rate clock output |
| cur_sel | output | 3 | Currently selected source code |
| clk_ok | output | 1 | High when no switch is in progress |
| osc_tick | output | 1 | Gated oscillator tick of the selected source |
| cpu_tick | output | 1 | Processor-clock tick after division |
| ckout | output | 1 | Clock output, toggling on each processor tick |

## Verification
The switch is driven through every valid code, first with all sources ticking every cycle. In that setting the length of the hold window separates the three delay rules: tick-counted plus fixed settle time, short tick-counted, and fixed time only. The sources are then given distinct periods from 2 to 7 cycles. The `osc_tick` count over a common window then identifies which input each code selects, so a wrong mapping cannot pass. The divider is run at N=0, 1, 3 and 255. A mid-period rewrite is checked by measuring two consecutive tick gaps, which separates adoption at the terminal count from immediate adoption.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NSRC = 6;

    localparam logic [2:0] SEL_XHI  = 3'b000;
    localparam logic [2:0] SEL_XMID = 3'b001;
    localparam logic [2:0] SEL_XLO  = 3'b010;
    localparam logic [2:0] SEL_RC   = 3'b011;
    localparam logic [2:0] SEL_WDOG = 3'b100;
    localparam logic [2:0] SEL_EXT  = 3'b111;

    typedef enum logic [1:0] {
        WS_RUN   = 2'd0,
        WS_TICKS = 2'd1,
        WS_TIME  = 2'd2
    } wake_st_e;

    function automatic logic sel_valid(input logic [2:0] code);
        return (code != 3'b101) && (code != 3'b110);
    endfunction

    function automatic logic sel_is_xtal(input logic [2:0] code);
        return (code == SEL_XHI) || (code == SEL_XMID) || (code == SEL_XLO);
    endfunction

    function automatic logic [2:0] sel_index(input logic [2:0] code);
        case (code)
            SEL_XHI:  return 3'd0;
            SEL_XMID: return 3'd1;
            SEL_XLO:  return 3'd2;
            SEL_RC:   return 3'd3;
            SEL_WDOG: return 3'd4;
            SEL_EXT:  return 3'd5;
            default:  return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/clksw_wake.sv
module clksw_wake
    import clksw_pkg::*;
#(
    parameter int XTAL_CNT    = 1024,
    parameter int XTAL_SETTLE = 40,
    parameter int FAST_CNT    = 32,
    parameter int RC_WAIT     = 150
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cfg_sel,
    input  logic [NSRC-1:0] src_tick,
    input  logic            ctl_we,
    input  logic [2:0]      ctl_sel,
    output logic [2:0]      sel_o,
    output logic            ok_o,
    output logic            start_o
);

    localparam int CW = $clog2(XTAL_CNT + XTAL_SETTLE + FAST_CNT + RC_WAIT + 1);
    localparam logic [CW-1:0] LIM_XTAL   = CW'(XTAL_CNT - 1);
    localparam logic [CW-1:0] LIM_FAST   = CW'(FAST_CNT - 1);
    localparam logic [CW-1:0] LIM_SETTLE = CW'(XTAL_SETTLE - 1);
    localparam logic [CW-1:0] LIM_RC     = CW'(RC_WAIT - 1);

    typedef struct packed {
        wake_st_e      st;
        logic [2:0]    sel;
        logic [CW-1:0] cnt;
        logic          ok;
    } wake_t;

    wake_t q, d;

    logic [7:0]    tick_pad;
    logic          sel_tick;
    logic          accept;
    logic [2:0]    rst_sel;
    logic [CW-1:0] tick_lim;
    logic [CW-1:0] time_lim;

    assign tick_pad = {{(8 - NSRC){1'b0}}, src_tick};
    assign sel_tick = tick_pad[sel_index(q.sel)];
    assign accept   = ctl_we && q.ok && sel_valid(ctl_sel);
    assign rst_sel  = sel_valid(cfg_sel) ? cfg_sel : SEL_RC;
    assign tick_lim = sel_is_xtal(q.sel) ? LIM_XTAL : LIM_FAST;
    assign time_lim = (q.sel == SEL_RC) ? LIM_RC : LIM_SETTLE;

    always_comb begin
        d = q;
        case (q.st)
            WS_RUN: begin
                if (accept) begin
                    d.sel = ctl_sel;
                    d.ok  = 1'b0;
                    d.cnt = '0;
                    d.st  = (ctl_sel == SEL_RC) ? WS_TIME : WS_TICKS;
                end
            end
            WS_TICKS: begin
                if (sel_tick) begin
                    if (q.cnt == tick_lim) begin
                        d.cnt = '0;
                        if (sel_is_xtal(q.sel)) begin
                            d.st = WS_TIME;
                        end else begin
                            d.st = WS_RUN;
                            d.ok = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (q.cnt == time_lim) begin
                    d.cnt = '0;
                    d.st  = WS_RUN;
                    d.ok  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= (rst_sel == SEL_RC) ? WS_TIME : WS_TICKS;
            q.sel <= rst_sel;
            q.cnt <= '0;
            q.ok  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sel_o   = q.sel;
    assign ok_o    = q.ok;
    assign start_o = accept;

    // R6: the ready flag drops only as a result of a control write
    p_okfall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok_o) |-> $past(ctl_we));

    // R7: a write during a switch leaves the selection untouched
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_o && ctl_we) |=> (sel_o == $past(sel_o)));

    // R8: a reserved code neither switches nor drops the ready flag
    p_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && ctl_we && !sel_valid(ctl_sel)) |=> (ok_o && $stable(sel_o)));

    // R2: the stored selection is always one of the six valid codes
    p_selvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid(sel_o));

endmodule

// File: rtl/clksw_div.sv
module clksw_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             restart,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ckout_en,
    output logic             cpu_tick,
    output logic             ckout
);

    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] nxt;
        logic             tick;
        logic             ck;
    } div_t;

    div_t q, d;

    logic [CNT_W-1:0] term;
    logic             at_term;

    assign term    = {q.act, 1'b0} - CNT_W'(1);
    assign at_term = (q.act == '0) || (q.cnt == term);

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (div_we) begin
            d.nxt = div_val;
        end
        if (restart) begin
            d.cnt = '0;
        end else if (osc_tick) begin
            if (at_term) begin
                d.tick = 1'b1;
                d.cnt  = '0;
                d.act  = q.nxt;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (!ckout_en) begin
            d.ck = 1'b0;
        end else if (d.tick) begin
            d.ck = ~q.ck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_tick = q.tick;
    assign ckout    = q.ck;

    // R9: the count never passes the 2N-1 terminal of the active divider
    p_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act != '0) |-> (q.cnt <= term));

    // R11: the clock output is parked low once disabled
    p_ckoff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ckout_en |=> !ckout);

endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int XTAL_CNT    = 1024,
    parameter int XTAL_SETTLE = 40,
    parameter int FAST_CNT    = 32,
    parameter int RC_WAIT     = 150,
    parameter int DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_sel,
    input  logic [5:0]       src_tick,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_sel,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ckout_en,
    output logic [2:0]       cur_sel,
    output logic             clk_ok,
    output logic             osc_tick,
    output logic             cpu_tick,
    output logic             ckout
);

    logic [7:0] tick_pad;
    logic       sw_start;

    clksw_wake #(
        .XTAL_CNT    (XTAL_CNT),
        .XTAL_SETTLE (XTAL_SETTLE),
        .FAST_CNT    (FAST_CNT),
        .RC_WAIT     (RC_WAIT)
    ) i_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel),
        .src_tick (src_tick),
        .ctl_we   (ctl_we),
        .ctl_sel  (ctl_sel),
        .sel_o    (cur_sel),
        .ok_o     (clk_ok),
        .start_o  (sw_start)
    );

    assign tick_pad = {2'b00, src_tick};
    assign osc_tick = tick_pad[sel_index(cur_sel)] & clk_ok;

    clksw_div #(
        .DIV_W (DIV_W)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .restart  (sw_start),
        .div_we   (div_we),
        .div_val  (div_val),
        .ckout_en (ckout_en),
        .cpu_tick (cpu_tick),
        .ckout    (ckout)
    );

    // R6: no processor tick follows a cycle spent holding the clock
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clk_ok) |-> !cpu_tick);

endmodule

// File: tb/test_clksw_top.sv
module test_clksw_top;

    localparam int XC = 1024;
    localparam int XS = 40;
    localparam int FC = 32;
    localparam int RW = 150;
    localparam int NT = 6;
    localparam logic [2:0] TSEL [NT] = '{3'b011, 3'b000, 3'b100, 3'b111, 3'b001, 3'b010};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_sel = 3'b110;
    logic [5:0] src_tick = '0;
    logic       ctl_we = 1'b0;
    logic [2:0] ctl_sel = '0;
    logic       div_we = 1'b0;
    logic [7:0] div_val = '0;
    logic       ckout_en = 1'b0;
    logic [2:0] cur_sel;
    logic       clk_ok, osc_tick, cpu_tick, ckout;

    int n_chk = 0;
    int n_bad = 0;
    int per [6] = '{1, 1, 1, 1, 1, 1};
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < 6; i++) src_tick[i] <= ((cyc % per[i]) == 0);
    end

    clksw_top #(.XTAL_CNT(XC), .XTAL_SETTLE(XS), .FAST_CNT(FC), .RC_WAIT(RW)) i_clksw_top (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .src_tick(src_tick),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .div_we(div_we), .div_val(div_val),
        .ckout_en(ckout_en), .cur_sel(cur_sel), .clk_ok(clk_ok), .osc_tick(osc_tick),
        .cpu_tick(cpu_tick), .ckout(ckout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int wait_of(input logic [2:0] c);
        if (c == 3'b011) return RW;
        if (c == 3'b100 || c == 3'b111) return FC;
        return XC + XS;
    endfunction

    function automatic int idx_of(input logic [2:0] c);
        return (c == 3'b111) ? 5 : int'(c);
    endfunction

    // write a code; leaves time at the sample point just after the write edge
    task automatic write_sel(input logic [2:0] c);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_sel = c;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic wait_ok();
        for (int k = 0; k < 20000 && !clk_ok; k++) step();
    endtask

    task automatic write_div(input logic [7:0] v);
        @(negedge clk);
        div_we = 1'b1;
        div_val = v;
        step();
        div_we = 1'b0;
    endtask

    initial begin
        int n, seen, cnt, tg, gap;
        repeat (3) step();
        // R1: reset state with a reserved configuration code
        check("R1 sel in reset", int'(cur_sel), 3);
        check("R1 ok in reset", int'(clk_ok), 0);
        check("R1 cpu_tick in reset", int'(cpu_tick), 0);
        check("R1 ckout in reset", int'(ckout), 0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        step();
        while (!clk_ok && n < 20000) begin n++; step(); end
        check("R1 start-up wait", n, RW - 1);

        // table walk: R3 R4 R5 R6 delays and hold
        for (int t = 0; t < NT; t++) begin
            write_sel(TSEL[t]);
            n = 0;
            seen = 0;
            while (!clk_ok && n < 20000) begin
                n++;
                if (osc_tick) seen++;
                step();
            end
            check("R3/R4/R5 wake delay (R3 R4 R5)", n, wait_of(TSEL[t]));
            check("R6 osc held during switch", seen, 0);
            check("R2 selected code", int'(cur_sel), int'(TSEL[t]));
        end

        // R7: write while busy is ignored
        write_sel(3'b011);
        ctl_we = 1'b1;
        ctl_sel = 3'b100;
        n = 1;
        step();
        ctl_we = 1'b0;
        while (!clk_ok && n < 20000) begin n++; step(); end
        check("R7 delay not restarted", n, RW);
        check("R7 selection kept", int'(cur_sel), 3);

        // R8: reserved codes ignored
        write_sel(3'b101);
        check("R8 ok stays for 101", int'(clk_ok), 1);
        check("R8 sel kept for 101", int'(cur_sel), 3);
        write_sel(3'b110);
        step();
        check("R8 ok stays for 110", int'(clk_ok), 1);
        check("R8 sel kept for 110", int'(cur_sel), 3);

        // R2: distinct periods identify the selected input
        for (int i = 0; i < 6; i++) per[i] = i + 2;
        for (int t = 0; t < NT; t++) begin
            write_sel(TSEL[t]);
            wait_ok();
            repeat (2) step();
            cnt = 0;
            for (int k = 0; k < 420; k++) begin
                if (osc_tick) cnt++;
                step();
            end
            check("R2 source mapping", cnt, 420 / (idx_of(TSEL[t]) + 2));
        end
        for (int i = 0; i < 6; i++) per[i] = 1;
        write_sel(3'b100);
        wait_ok();

        // R9 and R11: divide ratios with the clock output on
        ckout_en = 1'b1;
        foreach (TSEL[j]) begin
            logic [7:0] nv;
            int win;
            if (j > 3) break;
            nv = (j == 0) ? 8'd0 : (j == 1) ? 8'd1 : (j == 2) ? 8'd3 : 8'd255;
            win = (nv == 0) ? 50 : 4 * 2 * int'(nv);
            write_div(nv);
            repeat (600) step();
            cnt = 0;
            tg = 0;
            for (int k = 0; k < win; k++) begin
                logic prev;
                prev = ckout;
                if (cpu_tick) cnt++;
                step();
                if (ckout != prev) tg++;
            end
            check("R9 cpu ticks per window", cnt, (nv == 0) ? 50 : 4);
            check("R11 ckout toggles per cpu tick", tg, cnt);
        end
        ckout_en = 1'b0;
        step();
        seen = 0;
        for (int k = 0; k < 50; k++) begin
            if (ckout) seen++;
            step();
        end
        check("R11 ckout held low when disabled", seen, 0);

        // R10: mid-period rewrite applies at terminal count
        write_div(8'd2);
        repeat (20) step();
        while (!cpu_tick) step();
        write_div(8'd1);
        gap = 1;
        while (!cpu_tick && gap < 100) begin gap++; step(); end
        check("R10 old period completes", gap, 4);
        step();
        gap = 1;
        while (!cpu_tick && gap < 100) begin gap++; step(); end
        check("R10 new period used", gap, 2);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule